// File: doc/BRIEF.md
# Card-Memory DMA Transfer Engine

This block moves a byte stream between a host DMA channel and a 1 MB sample RAM on the card. Software programs a start address and a transfer mode, then sets the request bit in the control register. The engine raises a DMA request and accepts one byte per cycle on a valid/ready handshake. For each byte it issues one access on a simple byte-wide RAM port. The host marks the last byte with a terminal-count strobe. The engine then drops the request, moves the start address forward by the transfer length and can raise an interrupt.

The start address is split into two registers. A 16-bit register counts 16-byte units, and a separate low register supplies the byte offset within the unit in its bottom four bits. On a 16-bit channel the linear offset is remapped before use. The control register can be read back, and a read merges a channel-width flag and a pending-interrupt flag into the value returned, then clears them.

Top module: `gdma_engine`

## Requirements
- R1: After reset, the control register, both address registers and `irq_o` are zero, and no request, RAM access or returned byte is signalled.
- R2: A control write stores all 8 bits. While stored bit 0 is set, `dma_req_o` and `host_ready_o` are high, and they stay high until the terminal-count byte is accepted.
- R3: On an 8-bit channel, the first byte of a transfer goes to address start*16 + low[3:0]. Each following byte goes to the previous address plus one, wrapping within 20 bits.
- R4: On a 16-bit channel (`wide_chan_i`=1), the first address is (L AND 0xC0000) + 2*(L AND 0x1FFF0), where L is the linear offset from R3. Bytes then alternate low and high, starting with the low byte.
- R5: Control bit 1 selects the direction. With bit 1 = 0, each accepted byte is written to RAM. With bit 1 = 1, each accepted byte reads RAM, and the byte read appears on `dn_data_o` with `dn_valid_o` one cycle later, without modification.
- R6: On a RAM write, bit 7 of the byte is inverted when control bit 7 is set and the byte is either a high byte or a low byte with control bit 6 clear. When control bit 6 is set, low bytes pass unchanged.
- R7: When the terminal-count byte is accepted, stored control bit 0 clears. If control bit 5 is set, `irq_o` rises in the following cycle. If bit 5 is clear, `irq_o` is unchanged.
- R8: At terminal count, the transfer length N is counted in bytes on an 8-bit channel and in byte pairs on a 16-bit channel. The start register increases by N>>4, and low[3:0] becomes (N + old low[3:0]) mod 16.
- R9: `ctrl_rdata_o` equals the stored control value with bit 2 forced when `wide_chan_i` is 1 and bit 6 forced when the interrupt is pending. A read strobe clears the pending interrupt and clears stored bits 2 and 6.
- R10: A start-address write clears bits 7:4 of the low register. A low-register write stores all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_chan_i | input | 1 | Host channel is 16-bit |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_rd_i | input | 1 | Control register read strobe (read-to-clear) |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_rdata_o | output | 8 | Control read value with merged flags |
| start_wr_i | input | 1 | Start-address write strobe |
| start_wdata_i | input | 16 | Start address in 16-byte units |
| start_addr_o | output | 16 | Current start address |
| lo_wr_i | input | 1 | Low-address register write strobe |
| lo_wdata_i | input | 8 | Low-address write data |
| lo_addr_o | output | 8 | Current low-address register |
| dma_req_o | output | 1 | DMA request to host |
| host_valid_i | input | 1 | Host byte slot valid |
| host_ready_o | output | 1 | Engine accepts a byte slot |
| host_data_i | input | 8 | Host byte for upload |
| tc_i | input | 1 | Terminal count, marks the last byte |
| dn_valid_o | output | 1 | Download byte valid |
| dn_data_o | output | 8 | Download byte from RAM |
| irq_o | output | 1 | Terminal-count interrupt pending |
| ram_addr_o | output | 20 | RAM byte address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe (data next cycle) |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |

## Verification
The assertions check the following properties on every cycle: the request falls after terminal count, the interrupt rises when terminal-count interrupts are enabled, a read strobe clears the pending flag, a pending interrupt is reflected in the read value, no write occurs in the download direction, a download byte follows each read after one cycle, successive accesses use consecutive addresses, and a start write clears the upper low-register bits. The exact arithmetic can only be shown by the bench's scenarios. This covers the address translation on 16-bit channels, the choice of which bytes are inverted, and the start and low-nibble advance after transfers of different lengths. The bench compares each of these against its reference model on every clock, including a transfer that wraps at the top of the 20-bit space.

// File: rtl/gdma_pkg.sv
package gdma_pkg;
  localparam int CTL_REQ   = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_WIDE  = 2;
  localparam int CTL_TCIRQ = 5;
  localparam int CTL_D16   = 6;
  localparam int CTL_FLIP  = 7;
  localparam int LO_W      = 8;
  localparam int NIB_W     = 4;

  typedef enum logic {SLOT_LO = 1'b0, SLOT_HI = 1'b1} slot_e;
endpackage

// File: rtl/gdma_addr_gen.sv
module gdma_addr_gen #(
  parameter int START_W = 16,
  parameter int ADDR_W  = 20
) (
  input  logic [START_W-1:0] start_i,
  input  logic [3:0]         nib_i,
  input  logic               wide_i,
  output logic [ADDR_W-1:0]  base_o
);
  localparam logic [ADDR_W-1:0] HI_MASK  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] MID_MASK = ({ADDR_W{1'b1}} >> 3) & ~ADDR_W'(15);

  logic [ADDR_W-1:0] lin, trans;

  always_comb begin
    lin   = ADDR_W'({start_i, 4'b0000}) + ADDR_W'(nib_i);
    trans = (lin & HI_MASK) + ((lin & MID_MASK) << 1);
    base_o = wide_i ? trans : lin;
  end
endmodule

// File: rtl/gdma_byte_fmt.sv
module gdma_byte_fmt (
  input  logic [7:0] data_i,
  input  logic       upload_i,
  input  logic       flip_i,
  input  logic       d16_i,
  input  logic       hi_slot_i,
  output logic [7:0] data_o
);
  logic inv;
  // high bytes always follow flip; low bytes only for 8-bit data
  assign inv    = upload_i & flip_i & (hi_slot_i | ~d16_i);
  assign data_o = {data_i[7] ^ inv, data_i[6:0]};
endmodule

// File: rtl/gdma_ctrl.sv
module gdma_ctrl
  import gdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  input  logic       last_i,
  input  logic       wide_i,
  output logic [7:0] ctrl_o,
  output logic       irq_o,
  output logic [7:0] rdata_o
);
  logic [7:0] ctrl_q;
  logic       irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (rd_i) begin
        ctrl_q[CTL_WIDE] <= 1'b0;
        ctrl_q[CTL_D16]  <= 1'b0;
        irq_q            <= 1'b0;
      end
      if (last_i) begin
        ctrl_q[CTL_REQ] <= 1'b0;
        if (ctrl_q[CTL_TCIRQ]) irq_q <= 1'b1;
      end
      if (wr_i) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = ctrl_q;
    if (wide_i) rdata_o[CTL_WIDE] = 1'b1;
    if (irq_q)  rdata_o[CTL_D16]  = 1'b1;
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/gdma_engine.sv
module gdma_engine
  import gdma_pkg::*;
#(
  parameter int START_W = 16,
  parameter int ADDR_W  = 20,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wide_chan_i,
  input  logic               ctrl_wr_i,
  input  logic               ctrl_rd_i,
  input  logic [7:0]         ctrl_wdata_i,
  output logic [7:0]         ctrl_rdata_o,
  input  logic               start_wr_i,
  input  logic [START_W-1:0] start_wdata_i,
  output logic [START_W-1:0] start_addr_o,
  input  logic               lo_wr_i,
  input  logic [LO_W-1:0]    lo_wdata_i,
  output logic [LO_W-1:0]    lo_addr_o,
  output logic               dma_req_o,
  input  logic               host_valid_i,
  output logic               host_ready_o,
  input  logic [7:0]         host_data_i,
  input  logic               tc_i,
  output logic               dn_valid_o,
  output logic [7:0]         dn_data_o,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic               ram_we_o,
  output logic               ram_re_o,
  output logic [7:0]         ram_wdata_o,
  input  logic [7:0]         ram_rdata_i
);
  logic [7:0]         ctrl;
  logic [START_W-1:0] start_q;
  logic [LO_W-1:0]    lo_q;
  logic [ADDR_W-1:0]  ptr_q, base, cur_addr;
  logic               active_q, dnv_q;
  slot_e              slot_q;
  logic [CNT_W-1:0]   cnt_q, n_final;
  logic               xfer, last, upload, unit_inc, hi_slot;

  gdma_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr_i),
    .wdata_i (ctrl_wdata_i),
    .rd_i    (ctrl_rd_i),
    .last_i  (last),
    .wide_i  (wide_chan_i),
    .ctrl_o  (ctrl),
    .irq_o   (irq_o),
    .rdata_o (ctrl_rdata_o)
  );

  gdma_addr_gen #(.START_W(START_W), .ADDR_W(ADDR_W)) u_addr (
    .start_i (start_q),
    .nib_i   (lo_q[NIB_W-1:0]),
    .wide_i  (wide_chan_i),
    .base_o  (base)
  );

  gdma_byte_fmt u_fmt (
    .data_i    (host_data_i),
    .upload_i  (upload),
    .flip_i    (ctrl[CTL_FLIP]),
    .d16_i     (ctrl[CTL_D16]),
    .hi_slot_i (hi_slot),
    .data_o    (ram_wdata_o)
  );

  assign upload       = ~ctrl[CTL_DIR];
  assign host_ready_o = ctrl[CTL_REQ];
  assign dma_req_o    = ctrl[CTL_REQ];
  assign xfer         = host_valid_i & host_ready_o;
  assign last         = xfer & tc_i;
  assign hi_slot      = wide_chan_i & (slot_q == SLOT_HI);
  assign unit_inc     = ~wide_chan_i | (slot_q == SLOT_HI);
  assign n_final      = cnt_q + CNT_W'(unit_inc);
  assign cur_addr     = active_q ? ptr_q : base;

  assign ram_addr_o   = cur_addr;
  assign ram_we_o     = xfer & upload;
  assign ram_re_o     = xfer & ~upload;
  assign dn_valid_o   = dnv_q;
  assign dn_data_o    = ram_rdata_i;
  assign start_addr_o = start_q;
  assign lo_addr_o    = lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      lo_q     <= '0;
      ptr_q    <= '0;
      active_q <= 1'b0;
      slot_q   <= SLOT_LO;
      cnt_q    <= '0;
      dnv_q    <= 1'b0;
    end else begin
      dnv_q <= ram_re_o;
      if (last) begin
        active_q <= 1'b0;
        slot_q   <= SLOT_LO;
        cnt_q    <= '0;
        start_q  <= start_q + START_W'(n_final >> 4);
        lo_q[NIB_W-1:0] <= n_final[NIB_W-1:0] + lo_q[NIB_W-1:0];
      end else if (xfer) begin
        active_q <= 1'b1;
        ptr_q    <= cur_addr + ADDR_W'(1);
        slot_q   <= (wide_chan_i && slot_q == SLOT_LO) ? SLOT_HI : SLOT_LO;
        cnt_q    <= n_final;
      end
      if (lo_wr_i) lo_q <= lo_wdata_i;
      if (start_wr_i) begin
        start_q <= start_wdata_i;
        lo_q[LO_W-1:NIB_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/gdma_engine_chk.sv
module gdma_engine_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic              ctrl_rd_i,
  input logic              start_wr_i,
  input logic              lo_wr_i,
  input logic [7:0]        ctrl_rdata_o,
  input logic [7:0]        lo_addr_o,
  input logic              dma_req_o,
  input logic              host_valid_i,
  input logic              host_ready_o,
  input logic              tc_i,
  input logic              dn_valid_o,
  input logic              irq_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              ram_re_o
);
  logic hs, acc;
  assign hs  = host_valid_i & host_ready_o;
  assign acc = ram_we_o | ram_re_o;

  p_tc_drops_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && tc_i && !ctrl_wr_i) |=> !dma_req_o);

  p_tc_raises_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && tc_i && ctrl_rdata_o[5]) |=> irq_o);

  p_read_clears_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i && !(hs && tc_i)) |=> !irq_o);

  p_irq_flag_merged_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_rdata_o[6]);

  p_no_write_download_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (!ctrl_rdata_o[1] && !ram_re_o));

  p_read_returns_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> dn_valid_o);

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !tc_i) ##1 acc |-> ram_addr_o == ADDR_W'($past(ram_addr_o) + 1));

  p_nibble_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i && !lo_wr_i) |=> lo_addr_o[7:4] == 4'h0);
endmodule

bind gdma_engine gdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_wr_i    (ctrl_wr_i),
  .ctrl_rd_i    (ctrl_rd_i),
  .start_wr_i   (start_wr_i),
  .lo_wr_i      (lo_wr_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .lo_addr_o    (lo_addr_o),
  .dma_req_o    (dma_req_o),
  .host_valid_i (host_valid_i),
  .host_ready_o (host_ready_o),
  .tc_i         (tc_i),
  .dn_valid_o   (dn_valid_o),
  .irq_o        (irq_o),
  .ram_addr_o   (ram_addr_o),
  .ram_we_o     (ram_we_o),
  .ram_re_o     (ram_re_o)
);

// File: tb/gdma_engine_tb_top.sv
module gdma_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_chan_i = 1'b0;
  logic        ctrl_wr_i = 1'b0, ctrl_rd_i = 1'b0;
  logic [7:0]  ctrl_wdata_i = '0;
  logic [7:0]  ctrl_rdata_o;
  logic        start_wr_i = 1'b0;
  logic [15:0] start_wdata_i = '0;
  logic [15:0] start_addr_o;
  logic        lo_wr_i = 1'b0;
  logic [7:0]  lo_wdata_i = '0;
  logic [7:0]  lo_addr_o;
  logic        dma_req_o, host_ready_o;
  logic        host_valid_i = 1'b0;
  logic [7:0]  host_data_i = '0;
  logic        tc_i = 1'b0;
  logic        dn_valid_o;
  logic [7:0]  dn_data_o;
  logic        irq_o;
  logic [19:0] ram_addr_o;
  logic        ram_we_o, ram_re_o;
  logic [7:0]  ram_wdata_o;
  logic [7:0]  ram_rdata_i;
  logic [19:0] rd_addr_q = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  gdma_engine dut_i (.*);

  // RAM stand-in: read data is a function of the address read last cycle
  always @(posedge clk_i) if (ram_re_o) rd_addr_q <= ram_addr_o;
  assign ram_rdata_i = rd_addr_q[7:0] ^ 8'h5A;

  // reference model state
  int m_c, m_st, m_lo, m_irq, m_act, m_ptr, m_slot, m_cnt, m_dnv, m_rda;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_base();
    int lin;
    lin = (m_st * 16 + (m_lo & 15)) & 32'hFFFFF;
    if (wide_chan_i) return ((lin & 32'hC0000) + 2 * (lin & 32'h1FFF0)) & 32'hFFFFF;
    return lin;
  endfunction

  function automatic int m_addr();
    return m_act != 0 ? m_ptr : m_base();
  endfunction

  function automatic int m_wdata();
    bit hi, inv;
    hi  = wide_chan_i && m_slot != 0;
    inv = ((m_c >> 7) & 1) != 0 && (hi || ((m_c >> 6) & 1) == 0);
    return inv ? (int'(host_data_i) ^ 'h80) : int'(host_data_i);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_c = 0; m_st = 0; m_lo = 0; m_irq = 0; m_act = 0; m_ptr = 0;
      m_slot = 0; m_cnt = 0; m_dnv = 0; m_rda = 0;
    end else begin
      bit xfer, up, last, unit;
      int c0, a, n;
      c0   = m_c;
      xfer = host_valid_i && (c0 & 1) != 0;
      up   = ((c0 >> 1) & 1) == 0;
      last = xfer && tc_i;
      a    = m_addr();
      unit = !wide_chan_i || m_slot != 0;
      m_dnv = (xfer && !up) ? 1 : 0;
      if (xfer && !up) m_rda = a;
      if (ctrl_rd_i) begin m_c = m_c & 'hBB; m_irq = 0; end
      if (last) begin
        m_c = m_c & ~1;
        if ((c0 & 'h20) != 0) m_irq = 1;
      end
      if (ctrl_wr_i) m_c = int'(ctrl_wdata_i);
      if (last) begin
        n = m_cnt + int'(unit);
        m_st = (m_st + (n >> 4)) & 'hFFFF;
        m_lo = (m_lo & 'hF0) | ((n + m_lo) & 15);
        m_act = 0; m_slot = 0; m_cnt = 0;
      end else if (xfer) begin
        m_act = 1;
        m_ptr = (a + 1) & 32'hFFFFF;
        m_slot = (wide_chan_i && m_slot == 0) ? 1 : 0;
        m_cnt = m_cnt + int'(unit);
      end
      if (lo_wr_i) m_lo = int'(lo_wdata_i);
      if (start_wr_i) begin m_st = int'(start_wdata_i); m_lo = m_lo & 15; end
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit xfer, up;
      int rv;
      xfer = host_valid_i && (m_c & 1) != 0;
      up   = ((m_c >> 1) & 1) == 0;
      rv   = m_c | (wide_chan_i ? 4 : 0) | (m_irq != 0 ? 'h40 : 0);
      chk("R2 dma_req_o", int'(dma_req_o), m_c & 1);
      chk("R2 host_ready_o", int'(host_ready_o), m_c & 1);
      chk("R5 ram_we_o", int'(ram_we_o), (xfer && up) ? 1 : 0);
      chk("R5 ram_re_o", int'(ram_re_o), (xfer && !up) ? 1 : 0);
      if (xfer) chk(wide_chan_i ? "R4 ram_addr_o" : "R3 ram_addr_o", int'(ram_addr_o), m_addr());
      if (xfer && up) chk("R6 ram_wdata_o", int'(ram_wdata_o), m_wdata());
      chk("R5 dn_valid_o", int'(dn_valid_o), m_dnv);
      if (m_dnv != 0) chk("R5 dn_data_o", int'(dn_data_o), (m_rda & 'hFF) ^ 'h5A);
      chk("R7 irq_o", int'(irq_o), m_irq);
      chk("R9 ctrl_rdata_o", int'(ctrl_rdata_o), rv);
      chk("R8 start_addr_o", int'(start_addr_o), m_st);
      chk("R8 lo_addr_o", int'(lo_addr_o), m_lo);
    end
  end

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v; tick(); ctrl_wr_i = 1'b0;
  endtask

  task automatic rd_ctrl();
    ctrl_rd_i = 1'b1; tick(); ctrl_rd_i = 1'b0;
  endtask

  task automatic wr_start(input logic [15:0] v);
    start_wr_i = 1'b1; start_wdata_i = v; tick(); start_wr_i = 1'b0;
  endtask

  task automatic wr_lo(input logic [7:0] v);
    lo_wr_i = 1'b1; lo_wdata_i = v; tick(); lo_wr_i = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      host_valid_i = 1'b1;
      host_data_i  = seed + 8'(i * 37);
      tc_i         = (i == n - 1);
      tick();
    end
    host_valid_i = 1'b0; tc_i = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #35;
    // R1 reset state
    chk("R1 ctrl_rdata_o", int'(ctrl_rdata_o), 0);
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 dma_req_o", int'(dma_req_o), 0);
    chk("R1 start_addr_o", int'(start_addr_o), 0);
    chk("R1 ram_we_o", int'(ram_we_o | ram_re_o | dn_valid_o), 0);
    rst_ni = 1'b1;
    tick();

    // R10 low register upper bits cleared by start write
    wr_lo(8'hA7);
    chk("R10 lo write", int'(lo_addr_o), 'hA7);
    wr_start(16'h0012);
    chk("R10 lo after start write", int'(lo_addr_o), 'h07);

    // narrow upload, terminal-count interrupt
    wr_ctrl(8'h21);
    chk("R2 request raised", int'(dma_req_o), 1);
    send(5, 8'h90);
    chk("R7 request dropped", int'(dma_req_o), 0);
    chk("R7 irq raised", int'(irq_o), 1);
    chk("R8 nibble advance", int'(lo_addr_o), 12);
    chk("R9 merged read", int'(ctrl_rdata_o), 'h60);
    rd_ctrl();
    chk("R9 read clears irq", int'(irq_o), 0);

    // narrow upload with MSB flip, 20 bytes crosses a 16-byte unit
    wr_ctrl(8'h81);
    send(20, 8'h11);
    chk("R8 start advance", int'(start_addr_o), 'h13);
    chk("R8 nibble wrap", int'(lo_addr_o), 0);
    chk("R7 no irq without enable", int'(irq_o), 0);

    // 8-bit data flag with flip: low bytes pass unchanged
    wr_ctrl(8'hC1);
    send(4, 8'hF0);

    // 16-bit channel, translated address, hi bytes flipped
    wide_chan_i = 1'b1;
    wr_start(16'h5123);
    wr_lo(8'h00);
    wr_ctrl(8'hC1);
    chk("R9 wide flag in read", int'(ctrl_rdata_o), 'hC5);
    send(6, 8'h05);
    chk("R8 wide start advance", int'(start_addr_o), 'h5123);
    chk("R8 wide nibble", int'(lo_addr_o), 3);
    rd_ctrl();
    chk("R9 stored bit6 cleared", int'(ctrl_rdata_o), 'h84);
    wr_ctrl(8'hE1);
    send(34, 8'h33);
    rd_ctrl();
    wide_chan_i = 1'b0;

    // download: no inversion, data one cycle later
    wr_start(16'h0200);
    wr_ctrl(8'h83);
    send(4, 8'h00);
    chk("R5 download done", int'(dma_req_o), 0);

    // 20-bit wrap at top of memory
    wr_start(16'hFFFF);
    wr_lo(8'h0F);
    wr_ctrl(8'h01);
    send(3, 8'h7E);
    chk("R8 start wrap", int'(start_addr_o), 'hFFFF);
    chk("R8 nibble after wrap", int'(lo_addr_o), 2);

    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule